// File: doc/BRIEF.md
# Tree Address Walker

This block turns a variable-length virtual address into a 16-bit real memory address. Real memory is 256 pages of 256 sixteen-bit words. Every page is either a data page or a page table of 256 entries. The walk starts at the page table named by one of four context registers. Each incoming index byte picks an entry in the current table. The entry either names the next table, or names a data page whose word is then picked by the following byte. The depth of a walk therefore depends on the table contents and not on a fixed address format.

A caller pulses `start` with a context selected, then streams index bytes over a valid/ready interface, with `idx_last` marking the final byte. The walker reads one table entry per table step from a single-port memory that answers one cycle after the request. It ends each walk with a one-cycle `done` pulse and a 2-bit status. When the walk succeeds, it also returns the real address, the data page, the word offset and the last table visited. These let a jump-style register update load all three program-position fields at once.

Top module: `addr_walker`

## Requirements
- R1: While reset is held, and after it until `start`, `busy`, `done`, `idx_ready` and `mem_req` are all 0.
- R2: The first read of a walk targets address {root page, first byte}. The root page is byte k of `ctx_pages` (bits 8k+7:8k) for `ctx_sel` = k, where 0 is stack, 1 is program, 2 is data and 3 is general.
- R3: An entry with bit 15 clear is not in core. The walk ends with status 1.
- R4: An entry with bits 15 and 14 both set names a data page in bits 7:0. The next byte is the word offset. If that byte is the last, status is 0 and `real_addr` = {data page, offset}.
- R5: An entry with bit 15 set and bit 14 clear names the next page table in bits 7:0. The next byte's read goes to {that table, byte}.
- R6: If the byte stream ends on a table step, before any offset byte, status is 2.
- R7: If bytes follow the offset byte, status is 3.
- R8: `done` is high for exactly one cycle per walk. It rises one cycle after the final byte is accepted in the offset or drain phase, or one cycle after the entry read when a table step's byte was the last. `busy` is low in that cycle.
- R9: On status 0, `last_table` is the table that held the data-page entry, `data_page` is that page and `offset` is the final byte.
- R10: Bits 13:8 of an entry have no effect on the walk or on its results.
- R11: At most one read is outstanding. `mem_req` is never high in two consecutive cycles, and `idx_ready` is low in the cycle after a read request.
- R12: After a fault found on a byte that is not the last, every remaining byte up to and including the last is accepted before `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a walk (taken when idle) |
| ctx_sel | input | 2 | Context register selecting the root table |
| ctx_pages | input | 32 | Four context root pages, 8 bits each |
| idx_valid | input | 1 | Index byte valid |
| idx_byte | input | 8 | Index byte |
| idx_last | input | 1 | Marks the final byte of the address |
| idx_ready | output | 1 | Walker accepts an index byte |
| mem_req | output | 1 | Table-entry read request |
| mem_addr | output | 16 | Read address {table page, index} |
| mem_rdata | input | 16 | Entry data, valid the cycle after the request |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle completion pulse |
| status | output | 2 | 0 ok, 1 not in core, 2 too short, 3 too long |
| real_addr | output | 16 | Translated real address |
| last_table | output | 8 | Last page table visited |
| data_page | output | 8 | Data page reached |
| offset | output | 8 | Word offset within the data page |

## Verification
The assertions assume that the memory answers every request exactly one cycle later, and that the caller presents bytes only within a started walk, ending each walk with a byte marked last. The bench models memory as a fixed one-cycle array read. It pulses `start` only while the walker is idle, and it always finishes a byte sequence with `idx_last`. It varies the idle gaps between bytes to exercise the read-wait cycles against the ready handshake.

// File: rtl/aw_pkg.sv
package aw_pkg;

  typedef enum logic [1:0] {
    WS_OK     = 2'd0,
    WS_ABSENT = 2'd1,
    WS_SHORT  = 2'd2,
    WS_LONG   = 2'd3
  } walk_status_e;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_INDEX,
    PH_ENTRY,
    PH_OFFSET,
    PH_DRAIN
  } walk_phase_e;

endpackage

// File: rtl/aw_ctx_select.sv
module aw_ctx_select #(
  parameter int NUM_CTX = 4,
  parameter int PAGE_W  = 8,
  localparam int CTX_W  = (NUM_CTX > 1) ? $clog2(NUM_CTX) : 1
) (
  input  logic [NUM_CTX*PAGE_W-1:0] ctx_pages,
  input  logic [CTX_W-1:0]          sel,
  output logic [PAGE_W-1:0]         page
);

  logic [PAGE_W-1:0] slot [NUM_CTX];

  for (genvar g = 0; g < NUM_CTX; g++) begin : g_slot
    assign slot[g] = ctx_pages[g*PAGE_W +: PAGE_W];
  end

  always_comb begin
    page = '0;
    for (int k = 0; k < NUM_CTX; k++) begin
      if (sel == CTX_W'(k)) page = slot[k];
    end
  end

endmodule

// File: rtl/aw_pte_decode.sv
module aw_pte_decode #(
  parameter int WORD_W = 16,
  parameter int PAGE_W = 8
) (
  input  logic [WORD_W-1:0] entry,
  output logic              present,
  output logic              is_data,
  output logic [PAGE_W-1:0] target
);

  function automatic logic entry_present(input logic [WORD_W-1:0] e);
    return e[WORD_W-1];
  endfunction

  function automatic logic entry_is_data(input logic [WORD_W-1:0] e);
    return e[WORD_W-2];
  endfunction

  function automatic logic [PAGE_W-1:0] entry_target(input logic [WORD_W-1:0] e);
    return e[PAGE_W-1:0];
  endfunction

  assign present = entry_present(entry);
  assign is_data = entry_is_data(entry);
  assign target  = entry_target(entry);

  // protection field, reserved
  logic prot_unused;
  assign prot_unused = ^entry[WORD_W-3:PAGE_W];

endmodule

// File: rtl/aw_walk_ctrl.sv
module aw_walk_ctrl
  import aw_pkg::*;
#(
  parameter int PAGE_W  = 8,
  localparam int ADDR_W = 2 * PAGE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [PAGE_W-1:0] root_page,
  input  logic              idx_valid,
  input  logic [PAGE_W-1:0] idx_byte,
  input  logic              idx_last,
  output logic              idx_ready,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              pte_present,
  input  logic              pte_is_data,
  input  logic [PAGE_W-1:0] pte_target,
  output logic              busy,
  output logic              done,
  output logic [1:0]        status,
  output logic [ADDR_W-1:0] real_addr,
  output logic [PAGE_W-1:0] last_table,
  output logic [PAGE_W-1:0] data_page,
  output logic [PAGE_W-1:0] offset,
  output logic              ev_accept,
  output logic              ev_finish
);

  function automatic logic [ADDR_W-1:0] make_addr(input logic [PAGE_W-1:0] pg,
                                                  input logic [PAGE_W-1:0] wd);
    return {pg, wd};
  endfunction

  walk_phase_e       phase, phase_n;
  walk_status_e      pend, pend_n, fin_code;
  logic [PAGE_W-1:0] cur_tbl, tbl_n;
  logic [PAGE_W-1:0] dpage, dpage_n;
  logic [PAGE_W-1:0] ltbl, ltbl_n;
  logic              tail, tail_n;

  logic              done_q;
  logic [1:0]        status_q;
  logic [ADDR_W-1:0] real_addr_q;
  logic [PAGE_W-1:0] last_table_q, data_page_q, offset_q;

  assign idx_ready = (phase == PH_INDEX) || (phase == PH_OFFSET) || (phase == PH_DRAIN);
  assign ev_accept = idx_valid && idx_ready;
  assign mem_req   = (phase == PH_INDEX) && idx_valid;
  assign mem_addr  = make_addr(cur_tbl, idx_byte);
  assign busy      = (phase != PH_IDLE);

  always_comb begin
    phase_n   = phase;
    pend_n    = pend;
    tbl_n     = cur_tbl;
    dpage_n   = dpage;
    ltbl_n    = ltbl;
    tail_n    = tail;
    ev_finish = 1'b0;
    fin_code  = pend;
    unique case (phase)
      PH_IDLE: begin
        if (start) begin
          phase_n = PH_INDEX;
          tbl_n   = root_page;
          pend_n  = WS_OK;
        end
      end
      PH_INDEX: begin
        if (ev_accept) begin
          tail_n  = idx_last;
          phase_n = PH_ENTRY;
        end
      end
      PH_ENTRY: begin
        if (!pte_present) begin
          if (tail) begin
            ev_finish = 1'b1;
            fin_code  = WS_ABSENT;
            phase_n   = PH_IDLE;
          end else begin
            pend_n  = WS_ABSENT;
            phase_n = PH_DRAIN;
          end
        end else if (pte_is_data) begin
          dpage_n = pte_target;
          ltbl_n  = cur_tbl;
          if (tail) begin
            ev_finish = 1'b1;
            fin_code  = WS_SHORT;
            phase_n   = PH_IDLE;
          end else begin
            phase_n = PH_OFFSET;
          end
        end else begin
          tbl_n = pte_target;
          if (tail) begin
            ev_finish = 1'b1;
            fin_code  = WS_SHORT;
            phase_n   = PH_IDLE;
          end else begin
            phase_n = PH_INDEX;
          end
        end
      end
      PH_OFFSET: begin
        if (ev_accept) begin
          if (idx_last) begin
            ev_finish = 1'b1;
            fin_code  = WS_OK;
            phase_n   = PH_IDLE;
          end else begin
            pend_n  = WS_LONG;
            phase_n = PH_DRAIN;
          end
        end
      end
      PH_DRAIN: begin
        if (ev_accept && idx_last) begin
          ev_finish = 1'b1;
          fin_code  = pend;
          phase_n   = PH_IDLE;
        end
      end
      default: phase_n = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase        <= PH_IDLE;
      pend         <= WS_OK;
      cur_tbl      <= '0;
      dpage        <= '0;
      ltbl         <= '0;
      tail         <= 1'b0;
      done_q       <= 1'b0;
      status_q     <= '0;
      real_addr_q  <= '0;
      last_table_q <= '0;
      data_page_q  <= '0;
      offset_q     <= '0;
    end else begin
      phase   <= phase_n;
      pend    <= pend_n;
      cur_tbl <= tbl_n;
      dpage   <= dpage_n;
      ltbl    <= ltbl_n;
      tail    <= tail_n;
      done_q  <= ev_finish;
      if (ev_finish) status_q <= fin_code;
      if (ev_finish && fin_code == WS_OK) begin
        real_addr_q  <= make_addr(dpage, idx_byte);
        last_table_q <= ltbl;
        data_page_q  <= dpage;
        offset_q     <= idx_byte;
      end
    end
  end

  assign done       = done_q;
  assign status     = status_q;
  assign real_addr  = real_addr_q;
  assign last_table = last_table_q;
  assign data_page  = data_page_q;
  assign offset     = offset_q;

endmodule

// File: rtl/addr_walker.sv
module addr_walker #(
  parameter int NUM_CTX = 4,
  parameter int PAGE_W  = 8,
  parameter int WORD_W  = 16,
  localparam int CTX_W  = (NUM_CTX > 1) ? $clog2(NUM_CTX) : 1,
  localparam int ADDR_W = 2 * PAGE_W
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      start,
  input  logic [CTX_W-1:0]          ctx_sel,
  input  logic [NUM_CTX*PAGE_W-1:0] ctx_pages,
  input  logic                      idx_valid,
  input  logic [PAGE_W-1:0]         idx_byte,
  input  logic                      idx_last,
  output logic                      idx_ready,
  output logic                      mem_req,
  output logic [ADDR_W-1:0]         mem_addr,
  input  logic [WORD_W-1:0]         mem_rdata,
  output logic                      busy,
  output logic                      done,
  output logic [1:0]                status,
  output logic [ADDR_W-1:0]         real_addr,
  output logic [PAGE_W-1:0]         last_table,
  output logic [PAGE_W-1:0]         data_page,
  output logic [PAGE_W-1:0]         offset
);

  logic [PAGE_W-1:0] root_page;
  logic              pte_present;
  logic              pte_is_data;
  logic [PAGE_W-1:0] pte_target;
  logic              ev_accept;
  logic              ev_finish;

  aw_ctx_select #(.NUM_CTX(NUM_CTX), .PAGE_W(PAGE_W)) u_ctx (
    .ctx_pages (ctx_pages),
    .sel       (ctx_sel),
    .page      (root_page)
  );

  aw_pte_decode #(.WORD_W(WORD_W), .PAGE_W(PAGE_W)) u_dec (
    .entry   (mem_rdata),
    .present (pte_present),
    .is_data (pte_is_data),
    .target  (pte_target)
  );

  aw_walk_ctrl #(.PAGE_W(PAGE_W)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .root_page   (root_page),
    .idx_valid   (idx_valid),
    .idx_byte    (idx_byte),
    .idx_last    (idx_last),
    .idx_ready   (idx_ready),
    .mem_req     (mem_req),
    .mem_addr    (mem_addr),
    .pte_present (pte_present),
    .pte_is_data (pte_is_data),
    .pte_target  (pte_target),
    .busy        (busy),
    .done        (done),
    .status      (status),
    .real_addr   (real_addr),
    .last_table  (last_table),
    .data_page   (data_page),
    .offset      (offset),
    .ev_accept   (ev_accept),
    .ev_finish   (ev_finish)
  );

endmodule

// File: rtl/aw_walk_checker.sv
module aw_walk_checker #(
  parameter int PAGE_W  = 8,
  localparam int ADDR_W = 2 * PAGE_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              idx_valid,
  input logic              idx_ready,
  input logic [PAGE_W-1:0] idx_byte,
  input logic              mem_req,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              busy,
  input logic              done,
  input logic [1:0]        status,
  input logic [ADDR_W-1:0] real_addr,
  input logic [PAGE_W-1:0] data_page,
  input logic [PAGE_W-1:0] offset,
  input logic              ev_accept,
  input logic              ev_finish
);

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!idx_ready && !mem_req));

  p_read_index_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (idx_valid && ev_accept && mem_addr[PAGE_W-1:0] == idx_byte));

  p_start_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);

  p_ok_addr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (done && status == 2'd0) |-> (real_addr == {data_page, offset}));

  p_finish_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ev_finish |=> done);

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  p_single_read_r11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |=> !mem_req);

  p_wait_gap_r11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |=> !idx_ready);

endmodule

bind addr_walker aw_walk_checker #(.PAGE_W(PAGE_W)) u_walk_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .idx_valid (idx_valid),
  .idx_ready (idx_ready),
  .idx_byte  (idx_byte),
  .mem_req   (mem_req),
  .mem_addr  (mem_addr),
  .busy      (busy),
  .done      (done),
  .status    (status),
  .real_addr (real_addr),
  .data_page (data_page),
  .offset    (offset),
  .ev_accept (ev_accept),
  .ev_finish (ev_finish)
);

// File: tb/addr_walker_tb_top.sv
module addr_walker_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start;
  logic [1:0]  ctx_sel;
  logic [31:0] ctx_pages;
  logic        idx_valid;
  logic [7:0]  idx_byte;
  logic        idx_last;
  logic        idx_ready;
  logic        mem_req;
  logic [15:0] mem_addr;
  logic [15:0] mem_rdata;
  logic        busy, done;
  logic [1:0]  status;
  logic [15:0] real_addr;
  logic [7:0]  last_table, data_page, offset;

  always #5 clk = ~clk;

  addr_walker dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .ctx_sel(ctx_sel),
    .ctx_pages(ctx_pages), .idx_valid(idx_valid), .idx_byte(idx_byte),
    .idx_last(idx_last), .idx_ready(idx_ready), .mem_req(mem_req),
    .mem_addr(mem_addr), .mem_rdata(mem_rdata), .busy(busy), .done(done),
    .status(status), .real_addr(real_addr), .last_table(last_table),
    .data_page(data_page), .offset(offset)
  );

  logic [15:0] mem [0:65535];
  always @(posedge clk) if (mem_req) mem_rdata <= mem[mem_addr];

  int checks = 0;
  int fails  = 0;
  logic [15:0] exp_reads[$];
  logic [7:0]  seq[$];
  int          read_idx;
  logic        prev_req = 1'b0;
  logic [15:0] head_addr;

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic string status_tag(input int st);
    case (st)
      0: return "R4";
      1: return "R3";
      2: return "R6";
      default: return "R7";
    endcase
  endfunction

  // read monitor: compare each request with the model's next read
  always @(negedge clk) begin
    if (rst_n) begin
      if (mem_req) begin
        chk("R11", "read in consecutive cycles", 32'(prev_req), 0);
        if (exp_reads.size() == 0) begin
          chk("R2", "unexpected read", 1, 0);
        end else begin
          head_addr = exp_reads.pop_front();
          chk((read_idx == 0) ? "R2" : "R5", "read address", 32'(mem_addr), 32'(head_addr));
          read_idx++;
        end
      end
      prev_req = mem_req;
    end
  end

  task automatic run_walk(input int ctx, input int gap, input string addr_tag);
    logic [7:0] tbl = ctx_pages[ctx*8 +: 8];
    int phase = 0;
    int st = 0;
    bit end_on_read = 0;
    bit drained = 0;
    logic [7:0] dpg = 0, ltb = 0, off = 0;
    int delay;
    exp_reads.delete();
    read_idx = 0;
    for (int i = 0; i < seq.size(); i++) begin
      bit lst = (i == seq.size() - 1);
      logic [15:0] e;
      if (phase == 0) begin
        exp_reads.push_back({tbl, seq[i]});
        e = mem[{tbl, seq[i]}];
        if (e[15] == 1'b0) begin
          st = 1; phase = 2; end_on_read = lst; drained = !lst;
        end else if (e[14]) begin
          dpg = e[7:0]; ltb = tbl;
          if (lst) begin st = 2; end_on_read = 1; end else phase = 1;
        end else begin
          tbl = e[7:0];
          if (lst) begin st = 2; end_on_read = 1; end
        end
      end else if (phase == 1) begin
        off = seq[i];
        if (lst) st = 0; else begin st = 3; phase = 2; drained = 1; end
      end
    end
    delay = end_on_read ? 2 : 1;

    @(posedge clk); #2;
    start = 1'b1; ctx_sel = 2'(ctx);
    @(posedge clk); #2;
    start = 1'b0;
    for (int i = 0; i < seq.size(); i++) begin
      repeat (gap) begin @(posedge clk); #2; end
      idx_valid = 1'b1; idx_byte = seq[i]; idx_last = (i == seq.size() - 1);
      @(negedge clk);
      while (!idx_ready) @(negedge clk);
      @(posedge clk); #2;
      idx_valid = 1'b0; idx_last = 1'b0;
    end
    for (int k = 1; k <= 3; k++) begin
      @(negedge clk);
      if (k == delay) begin
        chk("R8", "done pulse", 32'(done), 1);
        chk(status_tag(st), "status", 32'(status), 32'(st));
        if (st == 0) begin
          chk(addr_tag, "real address", 32'(real_addr), 32'({dpg, off}));
          chk("R9", "last table", 32'(last_table), 32'(ltb));
          chk("R9", "data page", 32'(data_page), 32'(dpg));
          chk("R9", "offset", 32'(offset), 32'(off));
        end
      end else begin
        chk("R8", "done outside its cycle", 32'(done), 0);
      end
    end
    chk("R8", "busy after walk", 32'(busy), 0);
    chk("R2", "reads left unissued", 32'(exp_reads.size()), 0);
    if (drained) chk("R12", "stream drained before done", 32'(idx_ready), 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; ctx_sel = 2'd0; idx_valid = 1'b0;
    idx_byte = 8'h00; idx_last = 1'b0;
    ctx_pages = {8'h40, 8'h30, 8'h20, 8'h10};
    for (int a = 0; a < 65536; a++) mem[a] = 16'h0000;
    mem[16'h1005] = 16'hC077;
    mem[16'h1006] = 16'h8010;
    mem[16'h2001] = 16'hBF50;
    mem[16'h5002] = 16'hFF66;
    mem[16'h3000] = 16'h8031;
    mem[16'h31AA] = 16'h8032;
    mem[16'h3203] = 16'hC099;
    mem[16'h400B] = 16'h7FC5;

    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1", "busy in reset", 32'(busy), 0);
    chk("R1", "done in reset", 32'(done), 0);
    @(posedge clk); #2;
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "busy after reset", 32'(busy), 0);
    chk("R1", "idx_ready after reset", 32'(idx_ready), 0);
    chk("R1", "mem_req after reset", 32'(mem_req), 0);

    seq = '{8'h05, 8'h9A};                      run_walk(0, 0, "R4");
    seq = '{8'h01, 8'h02, 8'hFF};               run_walk(1, 1, "R10");
    seq = '{8'h00, 8'hAA, 8'h03, 8'h00};        run_walk(2, 0, "R5");
    seq = '{8'h06, 8'h06, 8'h05, 8'h9A};        run_walk(0, 2, "R5");
    seq = '{8'h07};                             run_walk(3, 0, "R3");
    seq = '{8'h0B, 8'h01, 8'h02};               run_walk(3, 1, "R10");
    seq = '{8'h05};                             run_walk(0, 0, "R6");
    seq = '{8'h01};                             run_walk(1, 0, "R6");
    seq = '{8'h05, 8'h9A, 8'h11, 8'h22};        run_walk(0, 0, "R7");
    seq = '{8'h00, 8'hAA, 8'h03, 8'h00, 8'h01}; run_walk(2, 1, "R7");
    seq = '{8'h05, 8'h9A};                      run_walk(0, 3, "R4");

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule